// File: doc/BRIEF.md
# Averaging Potentiometer Control Smoother

This block turns a noisy stream of 10-bit conversion results, taken from a delay-time knob, into a steady 24-bit desired delay measured in samples. Each result comes with a one-cycle valid strobe. The block sums a fixed block of 256 valid results. When a block is complete, it raises the total to a floor value if the total is too small. It then compares the total with the desired delay it currently holds.

The held value is replaced only when the new total has moved far enough from it. The test ignores the low byte of the difference. For a downward move, the size of the move is estimated with a bitwise inversion instead of a true negation. Any value that is stored has its least significant bit forced to zero, so a downstream slewer that steps in units of two can land on it exactly. A single-cycle pulse marks each update. After every block the running sum and the conversion count start over, whether or not an update took place.

Top module: `pot_smoother`

## Requirements
- R1: Only cycles with `adcValid` high add `adcData` into a 24-bit running sum. Cycles with `adcValid` low change neither the sum nor the conversion count. A block ends on the 256th valid conversion, and that conversion is included in the block total.
- R2: A block total below 0x000100 is replaced by exactly 0x000100 before the comparison. `desiredDelay` is never below 0x000100.
- R3: When the total is at or above the held value, the held value is replaced only if total minus held is 256 or more. A difference of 255 leaves it unchanged.
- R4: When the total is below the held value, the size of the move is the bitwise inverse of the 24-bit difference, which equals held minus total minus 1. The held value is replaced only if that size is 256 or more. This means a move down of 257 updates it and a move down of 256 does not.
- R5: A stored total has bit 0 cleared, so `desiredDelay` is always even.
- R6: After each block the running sum is zero and the count restarts at 256, so each block total depends only on its own conversions.
- R7: `desiredDelay` and `delayChanged` are registered. They take their new values at the clock edge that samples the final conversion of a block. `delayChanged` is high for exactly that one cycle, and only when the value was replaced.
- R8: While `rstN` is low, `desiredDelay` is 0x000100, `delayChanged` is 0, the sum is cleared and the count returns to 256. This also applies when reset arrives in the middle of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| adcValid | input | 1 | One-cycle strobe marking a new conversion result |
| adcData | input | 10 | Conversion result of the knob position |
| desiredDelay | output | 24 | Smoothed, even desired delay in samples |
| delayChanged | output | 1 | One-cycle pulse when `desiredDelay` is replaced |

## Verification
Two things happen in the same cycle here. The final conversion of a block is added to the sum, and that same sum is tested against the deadband and then cleared. The bench provokes this with blocks whose first 255 conversions leave the total just on the near side of a deadband edge, upward or downward. The last conversion then either tips the total over the edge or leaves it short by one. The scoreboard judges each block by the registered value and the pulse one cycle after that conversion, then checks that the pulse has dropped in the following cycle.

// File: rtl/pot_smoother_pkg.sv
package pot_smoother_pkg;

  // Strobes from the block counter to the datapath
  typedef struct packed {
    logic accumulate;  // add the current conversion to the running sum
    logic finish;      // current conversion closes the block
  } ctrlStrobe_t;

endpackage

// File: rtl/pot_smoother_ctrl.sv
module pot_smoother_ctrl
  import pot_smoother_pkg::*;
#(
  parameter int BLOCK_LEN = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        adcValid,
  output ctrlStrobe_t strobe
);

  localparam int CNT_W = $clog2(BLOCK_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BLOCK_LEN);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= CNT_FULL;
    end else if (adcValid) begin
      if (remaining == CNT_LAST) remaining <= CNT_FULL;
      else                       remaining <= remaining - CNT_W'(1);
    end
  end

  always_comb begin
    strobe.accumulate = adcValid;
    strobe.finish     = adcValid && (remaining == CNT_LAST);
  end

  // R1
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remaining != '0) && (remaining <= CNT_FULL));

  // R1
  idle_holds_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !adcValid |=> $stable(remaining));

  // R6
  count_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> (remaining == CNT_FULL));

endmodule

// File: rtl/pot_smoother_dp.sv
module pot_smoother_dp
  import pot_smoother_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int SUM_W     = 24,
  parameter int MIN_DELAY = 256,
  parameter int DEAD_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] adcData,
  output logic [SUM_W-1:0]  desiredDelay,
  output logic              delayChanged
);

  localparam logic [SUM_W-1:0] FLOOR_VAL  = SUM_W'(MIN_DELAY);
  localparam logic [SUM_W-1:0] DEAD_LIMIT = SUM_W'(1) << DEAD_BITS;
  localparam logic [SUM_W-1:0] EVEN_MASK  = ~SUM_W'(1);

  logic [SUM_W-1:0] accSum;
  logic [SUM_W-1:0] sumNext;
  logic [SUM_W-1:0] clampedSum;
  logic [SUM_W-1:0] rawDiff;
  logic [SUM_W-1:0] moveSize;
  logic             movingDown;
  logic             bigMove;

  // Block total including the conversion on the current cycle
  always_comb begin
    sumNext    = accSum + SUM_W'(adcData);
    clampedSum = (sumNext < FLOOR_VAL) ? FLOOR_VAL : sumNext;
  end

  // Deadband test: the size of a downward move is the inverted difference
  always_comb begin
    rawDiff    = clampedSum - desiredDelay;
    movingDown = clampedSum < desiredDelay;
    moveSize   = movingDown ? ~rawDiff : rawDiff;
    bigMove    = moveSize >= DEAD_LIMIT;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accSum <= '0;
    end else if (strobe.finish) begin
      accSum <= '0;
    end else if (strobe.accumulate) begin
      accSum <= sumNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      desiredDelay <= FLOOR_VAL;
      delayChanged <= 1'b0;
    end else begin
      delayChanged <= strobe.finish && bigMove;
      if (strobe.finish && bigMove) desiredDelay <= clampedSum & EVEN_MASK;
    end
  end

  // R5
  even_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    desiredDelay[0] == 1'b0);

  // R2
  floor_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    desiredDelay >= FLOOR_VAL);

  // R6
  sum_cleared_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> (accSum == '0));

  // R1
  idle_holds_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.accumulate |=> $stable(accSum));

  // R7
  update_only_at_finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(desiredDelay));

  // R7
  pulse_marks_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    delayChanged |-> (desiredDelay != $past(desiredDelay)));

endmodule

// File: rtl/pot_smoother.sv
module pot_smoother
  import pot_smoother_pkg::*;
#(
  parameter int DATA_W    = 10,
  parameter int SUM_W     = 24,
  parameter int BLOCK_LEN = 256,
  parameter int MIN_DELAY = 256,
  parameter int DEAD_BITS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcValid,
  input  logic [DATA_W-1:0] adcData,
  output logic [SUM_W-1:0]  desiredDelay,
  output logic              delayChanged
);

  ctrlStrobe_t strobe;

  pot_smoother_ctrl #(
    .BLOCK_LEN(BLOCK_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .adcValid(adcValid),
    .strobe  (strobe)
  );

  pot_smoother_dp #(
    .DATA_W   (DATA_W),
    .SUM_W    (SUM_W),
    .MIN_DELAY(MIN_DELAY),
    .DEAD_BITS(DEAD_BITS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .adcData     (adcData),
    .desiredDelay(desiredDelay),
    .delayChanged(delayChanged)
  );

endmodule

// File: tb/pot_smoother_bench.sv
`timescale 1ns/1ps
module pot_smoother_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        adcValid = 1'b0;
  logic [9:0]  adcData = '0;
  logic [23:0] desiredDelay;
  logic        delayChanged;

  int testsRun = 0;
  int testsFailed = 0;

  logic [23:0] expDelayQ[$];
  bit          expChgQ[$];
  string       tagQ[$];

  logic [23:0] modelDelay = 24'h000100;
  bit          isLast = 1'b0;
  logic        lastSeen = 1'b0;
  bit          expectLow = 1'b0;
  string       lowTag;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pot_smoother u_pot_smoother (
    .clk(clk), .rstN(rstN), .adcValid(adcValid), .adcData(adcData),
    .desiredDelay(desiredDelay), .delayChanged(delayChanged)
  );

  task automatic check(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=0x%06h expected=0x%06h", tag, act, exp);
    end
  endtask

  // Driver: 255 conversions of baseVal, then lastVal; the expected outcome is queued
  task automatic runBlock(input int baseVal, input int lastVal, input bit gaps, input string tag);
    int total;
    int diffUp;
    int downSize;
    bit upd;
    total = 255 * baseVal + lastVal;
    if (total < 256) total = 256;                      // R2 floor
    if (total >= int'(modelDelay)) begin
      diffUp = total - int'(modelDelay);
      upd = diffUp >= 256;                             // R3
    end else begin
      downSize = int'(modelDelay) - total - 1;         // R4 inverted difference
      upd = downSize >= 256;
    end
    if (upd) modelDelay = 24'(total) & 24'hFFFFFE;     // R5 even
    expDelayQ.push_back(modelDelay);
    expChgQ.push_back(upd);
    tagQ.push_back(tag);
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      adcValid = 1'b1;
      adcData  = 10'((i == 255) ? lastVal : baseVal);
      isLast   = (i == 255);
      if (gaps) begin
        @(negedge clk);
        adcValid = 1'b0;                                // R1 ignored cycle
        adcData  = 10'h3FF;
        isLast   = 1'b0;
      end
    end
    @(negedge clk);
    adcValid = 1'b0;
    isLast   = 1'b0;
  endtask

  always @(posedge clk) lastSeen <= rstN && adcValid && isLast;

  // Monitor: compares each block result one cycle after its final conversion
  always @(negedge clk) begin
    if (expectLow) begin
      check(delayChanged == 1'b0, {"R7 pulse single cycle ", lowTag}, 24'(delayChanged), 24'h0);
      expectLow = 1'b0;
    end
    if (lastSeen && expDelayQ.size() > 0) begin
      logic [23:0] eDel;
      bit eChg;
      string tg;
      eDel = expDelayQ.pop_front();
      eChg = expChgQ.pop_front();
      tg   = tagQ.pop_front();
      check(desiredDelay == eDel, {tg, " delay"}, desiredDelay, eDel);
      check(delayChanged == eChg, {"R7 ", tg, " pulse"}, 24'(delayChanged), 24'(eChg));
      if (eChg) begin
        expectLow = 1'b1;
        lowTag = tg;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(desiredDelay == 24'h000100, "R8 reset delay", desiredDelay, 24'h000100);
    check(delayChanged == 1'b0, "R8 reset pulse", 24'(delayChanged), 24'h0);
    rstN = 1'b1;

    runBlock(0, 0, 1'b0, "R2 zero block floor");
    runBlock(4, 4, 1'b0, "R6 first rise to 0x400");
    runBlock(5, 4, 1'b0, "R3 up by 255 held");
    runBlock(5, 5, 1'b1, "R1 R3 up by 256 with idle gaps");
    runBlock(6, 7, 1'b0, "R5 odd total 0x601");
    runBlock(5, 5, 1'b0, "R4 down by 256 held");
    runBlock(5, 4, 1'b0, "R4 down by 257 odd");
    runBlock(0, 0, 1'b1, "R2 floor from above");
    runBlock(1023, 1023, 1'b0, "R6 full scale");

    // R8: reset in the middle of a block
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      adcValid = 1'b1;
      adcData  = 10'h3FF;
    end
    @(negedge clk);
    adcValid = 1'b0;
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(desiredDelay == 24'h000100, "R8 mid-block reset delay", desiredDelay, 24'h000100);
    rstN = 1'b1;
    modelDelay = 24'h000100;
    runBlock(3, 3, 1'b0, "R8 count restarted after reset");

    repeat (4) @(negedge clk);
    check(expDelayQ.size() == 0, "R7 all results seen", 24'(expDelayQ.size()), 24'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog expired actual=0x%06h expected=0x%06h", 24'(0), 24'(1));
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule